// File: doc/BRIEF.md
# Erased-Sector ECC Parity Filter

This block wraps a Reed-Solomon style ECC engine that protects 512-byte sectors with 9 parity bytes, and it gives erased sectors special handling. When a sector is programmed, the encoder's parity is checked against the parity of a sector that holds only 0xFF bytes. On a match, nine 0xFF bytes are written in place of that parity, so the spare area of an all-0xFF sector still reads as erased flash. On any other result the parity passes through unchanged.

On read, the block counts the 512 data bytes and then the 9 stored parity bytes as they stream past. It keeps a running AND over them, and a sector start clears it. When every byte is 0xFF, the sector is flagged blank, the decoder is never told that parity is ready, and a decode-finished report with zero errors is produced locally. Otherwise the block raises parity-ready on the engine's control word and forwards the decoder's status when the decoder finishes. The block also drives the engine control word for each sector.

Top module: `erased_par_filter`

## Requirements
- R1: After reset, every output is zero: the control word, the parity strobe and value, the blank strobe and flag, and the report strobe, status and error count.
- R2: The cycle after `secStart` is sampled, the control word has bit 0 (enable), bit 1 (engine reset) and bit 2 (RS mode) set. Bit 3 equals `secWrite` (1 for program, 0 for read) and bit 4 (parity ready) is clear. Bit 1 stays set for exactly one cycle.
- R3: In a program sector, `encDone` raises `parOutValid` for one cycle on the following cycle and clears the control word. `parOut` is 72 ones when `encParity` equals the erased signature; otherwise `parOut` equals `encParity`. The signature is CD 9D 90 58 F4 8B FF B7 6F, with parity byte k at bits 8k+7:8k, so bits 7:0 hold CD and bits 71:64 hold 6F.
- R4: In a read sector, every cycle with `byteValid` high accepts one byte. The first 512 bytes are data and the next 9 are parity. One cycle after the 521st byte, `blankValid` pulses for one cycle. `blank` is 1 only if all 521 bytes were 0xFF, and it holds until the next `secStart`.
- R5: A single byte other than 0xFF, at any data or parity position, makes `blank` 0 for that sector.
- R6: For a blank sector, `rptValid` pulses in the same cycle as `blankValid`. `rptStatus` is 5'b01000, where bit 3 is decode finish; bit 0 (error), bit 1 (uncorrectable), bit 2 (encode finish) and bit 4 (pad finish) are zero. `rptErrCnt` is 0, and the control word returns to zero with parity ready never set.
- R7: For a non-blank sector, control bit 4 (parity ready) is set in the `blankValid` cycle and held until `decStatus` bit 3 is seen. One cycle after that, `rptValid` pulses, `rptStatus` and `rptErrCnt` carry the decoder's values, and the control word is zero.
- R8: `secStart` restarts the block from any state: the byte count and the running AND are cleared, and the new mode takes over.
- R9: `byteValid` outside read loading, and `encDone` outside a program sector waiting for parity, are ignored. Neither produces a strobe, changes the control word or advances the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secStart | input | 1 | Begin a sector (pulse) |
| secWrite | input | 1 | Sector mode at start: 1 program, 0 read |
| byteValid | input | 1 | Read stream byte present |
| byteIn | input | 8 | Read stream byte |
| encDone | input | 1 | Encoder finished; parity valid |
| encParity | input | 72 | Encoder parity, byte k at bits 8k+7:8k |
| decStatus | input | 5 | Decoder status word (bit 3 decode finish) |
| decErrCnt | input | 3 | Decoder corrected-error count |
| eccCtrl | output | 5 | Engine control word |
| parOutValid | output | 1 | Parity to store is valid (pulse) |
| parOut | output | 72 | Parity to store |
| blankValid | output | 1 | Blank decision is valid (pulse) |
| blank | output | 1 | Sector was fully erased |
| rptValid | output | 1 | Read report valid (pulse) |
| rptStatus | output | 5 | Reported status word |
| rptErrCnt | output | 3 | Reported error count |

## Verification
A byte counter that is off by one shows up at the ports as a `blankValid` pulse one cycle early or late relative to the 521st byte. A position that the running AND misses shows up as a wrong `blank` flag for that byte position alone. The bench therefore sweeps a bad byte across both boundaries of the data and parity regions, adds idle gaps, and checks the exact pulse cycle. A faulty signature compare shows up on the very next `parOutValid`, so every single-bit flip of the signature is checked for pass-through. A stuck state is seen at once in the control word.

// File: rtl/erased_par_pkg.sv
package erased_par_pkg;
  // control word bit positions (decoded by the ECC engine)
  localparam int CB_EN  = 0;
  localparam int CB_RST = 1;
  localparam int CB_RS  = 2;
  localparam int CB_ENC = 3;
  localparam int CB_PRDY = 4;
  localparam int CTRL_W = 5;
  // status word bit positions
  localparam int ST_ERR = 0;
  localparam int ST_UNC = 1;
  localparam int ST_ENC = 2;
  localparam int ST_DEC = 3;
  localparam int ST_PAD = 4;
  localparam int STAT_W = 5;
  localparam int ERRC_W = 3;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_WR_WAIT = 2'd1,
    S_RD_LOAD = 2'd2,
    S_RD_DEC  = 2'd3
  } phase_t;

  typedef struct packed {
    logic clrSec;
    logic takeByte;
    logic rdFinish;
    logic capPar;
    logic capRpt;
  } strobe_t;
endpackage

// File: rtl/erased_par_ctl.sv
module erased_par_ctl
  import erased_par_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secStart,
  input  logic              secWrite,
  input  logic              byteValid,
  input  logic              encDone,
  input  logic              decDone,
  input  logic              lastByte,
  input  logic              blankNow,
  output strobe_t           stb,
  output logic [CTRL_W-1:0] eccCtrl
);
  phase_t state;

  always_comb begin
    stb = '0;
    stb.clrSec   = secStart;
    stb.takeByte = !secStart && (state == S_RD_LOAD) && byteValid;
    stb.rdFinish = stb.takeByte && lastByte;
    stb.capPar   = !secStart && (state == S_WR_WAIT) && encDone;
    stb.capRpt   = !secStart && (state == S_RD_DEC) && decDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      eccCtrl <= '0;
    end else if (secStart) begin
      state            <= secWrite ? S_WR_WAIT : S_RD_LOAD;
      eccCtrl          <= '0;
      eccCtrl[CB_EN]   <= 1'b1;
      eccCtrl[CB_RST]  <= 1'b1;
      eccCtrl[CB_RS]   <= 1'b1;
      eccCtrl[CB_ENC]  <= secWrite;
    end else begin
      eccCtrl[CB_RST] <= 1'b0;
      if (stb.capPar || stb.capRpt) begin
        state   <= S_IDLE;
        eccCtrl <= '0;
      end else if (stb.rdFinish) begin
        if (blankNow) begin
          state   <= S_IDLE;
          eccCtrl <= '0;
        end else begin
          state            <= S_RD_DEC;
          eccCtrl[CB_PRDY] <= 1'b1;
          eccCtrl[CB_RST]  <= 1'b0;
        end
      end
    end
  end

  // R2: engine reset bit lasts a single cycle
  a_r2_reset_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (eccCtrl[CB_RST] && !secStart) |=> !eccCtrl[CB_RST]);
  // R7: parity ready only ever in decode mode
  a_r7_prdy_read_only: assert property (@(posedge clk) disable iff (!rstN)
    eccCtrl[CB_PRDY] |-> !eccCtrl[CB_ENC]);
  // R7: parity ready holds until the decoder finishes
  a_r7_prdy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (eccCtrl[CB_PRDY] && !decDone && !secStart) |=> eccCtrl[CB_PRDY]);
  // R9: idle means the engine is not driven
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> (eccCtrl == '0));
endmodule

// File: rtl/erased_par_dp.sv
module erased_par_dp
  import erased_par_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PAR_BYTES    = 9,
  parameter int BYTE_W       = 8,
  parameter logic [PAR_BYTES*BYTE_W-1:0] ERASED_SIG = '0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [BYTE_W-1:0]           byteIn,
  input  logic [PAR_BYTES*BYTE_W-1:0] encParity,
  input  logic [STAT_W-1:0]           decStatus,
  input  logic [ERRC_W-1:0]           decErrCnt,
  output logic                        lastByte,
  output logic                        blankNow,
  output logic                        parOutValid,
  output logic [PAR_BYTES*BYTE_W-1:0] parOut,
  output logic                        blankValid,
  output logic                        blank,
  output logic                        rptValid,
  output logic [STAT_W-1:0]           rptStatus,
  output logic [ERRC_W-1:0]           rptErrCnt
);
  localparam int TOTAL = SECTOR_BYTES + PAR_BYTES;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int PAR_W = PAR_BYTES * BYTE_W;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0]     byteCnt;
  logic                 runAnd;
  logic [PAR_BYTES-1:0] byteMatch;
  logic                 sigHit;

  // per-byte signature compare
  for (genvar k = 0; k < PAR_BYTES; k++) begin : g_cmp
    assign byteMatch[k] =
      (encParity[k*BYTE_W +: BYTE_W] == ERASED_SIG[k*BYTE_W +: BYTE_W]);
  end
  assign sigHit   = &byteMatch;
  assign lastByte = (byteCnt == LAST_IDX);
  assign blankNow = runAnd && (&byteIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      runAnd  <= 1'b1;
    end else if (stb.clrSec) begin
      byteCnt <= '0;
      runAnd  <= 1'b1;
    end else if (stb.takeByte) begin
      byteCnt <= byteCnt + 1'b1;
      runAnd  <= blankNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parOutValid <= 1'b0;
      parOut      <= '0;
      blankValid  <= 1'b0;
      blank       <= 1'b0;
      rptValid    <= 1'b0;
      rptStatus   <= '0;
      rptErrCnt   <= '0;
    end else begin
      parOutValid <= stb.capPar;
      blankValid  <= stb.rdFinish;
      rptValid    <= stb.capRpt || (stb.rdFinish && blankNow);
      if (stb.clrSec) blank <= 1'b0;
      if (stb.capPar) parOut <= sigHit ? {PAR_W{1'b1}} : encParity;
      if (stb.rdFinish) begin
        blank <= blankNow;
        if (blankNow) begin
          rptStatus         <= '0;
          rptStatus[ST_DEC] <= 1'b1;
          rptErrCnt         <= '0;
        end
      end
      if (stb.capRpt) begin
        rptStatus <= decStatus;
        rptErrCnt <= decErrCnt;
      end
    end
  end

  // R3: erased signature becomes all ones
  a_r3_sig_erased: assert property (@(posedge clk) disable iff (!rstN)
    (parOutValid && ($past(encParity) == ERASED_SIG)) |-> (&parOut));
  // R3: any other parity passes through
  a_r3_pass: assert property (@(posedge clk) disable iff (!rstN)
    (parOutValid && ($past(encParity) != ERASED_SIG)) |-> (parOut == $past(encParity)));
  // R4: blank decision is a single-cycle pulse
  a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    blankValid |=> !blankValid);
  // R6: blank sector reports decode finish with zero errors
  a_r6_blank_rpt: assert property (@(posedge clk) disable iff (!rstN)
    (blankValid && blank) |-> (rptValid && rptErrCnt == '0 && rptStatus == 5'b01000));
endmodule

// File: rtl/erased_par_filter.sv
module erased_par_filter
  import erased_par_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PAR_BYTES    = 9,
  parameter int BYTE_W       = 8,
  parameter logic [PAR_BYTES*BYTE_W-1:0] ERASED_SIG =
    72'h6F_B7_FF_8B_F4_58_90_9D_CD
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        secStart,
  input  logic                        secWrite,
  input  logic                        byteValid,
  input  logic [BYTE_W-1:0]           byteIn,
  input  logic                        encDone,
  input  logic [PAR_BYTES*BYTE_W-1:0] encParity,
  input  logic [STAT_W-1:0]           decStatus,
  input  logic [ERRC_W-1:0]           decErrCnt,
  output logic [CTRL_W-1:0]           eccCtrl,
  output logic                        parOutValid,
  output logic [PAR_BYTES*BYTE_W-1:0] parOut,
  output logic                        blankValid,
  output logic                        blank,
  output logic                        rptValid,
  output logic [STAT_W-1:0]           rptStatus,
  output logic [ERRC_W-1:0]           rptErrCnt
);
  strobe_t stb;
  logic    lastByte;
  logic    blankNow;

  erased_par_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .secStart (secStart),
    .secWrite (secWrite),
    .byteValid(byteValid),
    .encDone  (encDone),
    .decDone  (decStatus[ST_DEC]),
    .lastByte (lastByte),
    .blankNow (blankNow),
    .stb      (stb),
    .eccCtrl  (eccCtrl)
  );

  erased_par_dp #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .PAR_BYTES   (PAR_BYTES),
    .BYTE_W      (BYTE_W),
    .ERASED_SIG  (ERASED_SIG)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .byteIn     (byteIn),
    .encParity  (encParity),
    .decStatus  (decStatus),
    .decErrCnt  (decErrCnt),
    .lastByte   (lastByte),
    .blankNow   (blankNow),
    .parOutValid(parOutValid),
    .parOut     (parOut),
    .blankValid (blankValid),
    .blank      (blank),
    .rptValid   (rptValid),
    .rptStatus  (rptStatus),
    .rptErrCnt  (rptErrCnt)
  );
endmodule

// File: tb/erased_par_filter_tb.sv
module erased_par_filter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secStart = 1'b0, secWrite = 1'b0, byteValid = 1'b0, encDone = 1'b0;
  logic [7:0]  byteIn = 8'h00;
  logic [71:0] encParity = '0;
  logic [4:0]  decStatus = '0;
  logic [2:0]  decErrCnt = '0;
  logic [4:0]  eccCtrl;
  logic        parOutValid, blankValid, blank, rptValid;
  logic [71:0] parOut;
  logic [4:0]  rptStatus;
  logic [2:0]  rptErrCnt;

  int checks = 0;
  int failures = 0;
  logic [71:0] sig;
  localparam int TOTAL = 521;

  always #10 clk = ~clk;

  erased_par_filter u_dut (.*);

  task automatic chk(input logic ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic startSec(input logic wr);
    secStart = 1'b1; secWrite = wr;
    cyc();
    secStart = 1'b0;
    // R2: en, reset, rs set, bit3 = mode
    chk(eccCtrl == {1'b0, wr, 3'b111}, "R2 ctrl after start", eccCtrl, {1'b0, wr, 3'b111});
    cyc();
    chk(eccCtrl == {1'b0, wr, 3'b101}, "R2 reset bit one cycle", eccCtrl, {1'b0, wr, 3'b101});
  endtask

  // feed a read sector; badPos < 0 means all 0xFF
  task automatic feed(input int badPos, input logic [7:0] badVal, input bit gaps);
    bit early = 0;
    for (int i = 0; i < TOTAL; i++) begin
      if (gaps && (i % 7 == 3)) begin
        byteValid = 1'b0; cyc();
      end
      byteValid = 1'b1;
      byteIn = (i == badPos) ? badVal : 8'hFF;
      cyc();
      if (i < TOTAL - 1 && blankValid) early = 1;
    end
    byteValid = 1'b0;
    chk(!early, "R4 no early blankValid", early, 0);
  endtask

  task automatic readSector(input int badPos, input logic [7:0] badVal, input bit gaps);
    logic expBlank;
    expBlank = (badPos < 0) || (badVal == 8'hFF);
    startSec(1'b0);
    feed(badPos, badVal, gaps);
    chk(blankValid == 1'b1, "R4 blankValid after last byte", blankValid, 1);
    chk(blank == expBlank, "R5 blank flag", blank, expBlank);
    if (expBlank) begin
      chk(rptValid && rptStatus == 5'b01000 && rptErrCnt == 0, "R6 blank report",
          {rptValid, rptStatus, rptErrCnt}, {1'b1, 5'b01000, 3'b0});
      chk(eccCtrl == 5'b0, "R6 ctrl cleared, no parity ready", eccCtrl, 0);
      cyc();
      chk(!blankValid && !rptValid && blank, "R4 pulse ends, flag holds",
          {blankValid, rptValid, blank}, 3'b001);
    end else begin
      chk(!rptValid && eccCtrl == 5'b10101, "R7 parity ready set", {rptValid, eccCtrl}, 6'b010101);
      cyc(); cyc();
      // R9: bytes ignored while decoding
      byteValid = 1'b1; byteIn = 8'h00; cyc(); byteValid = 1'b0;
      chk(eccCtrl == 5'b10101 && !rptValid && !blankValid, "R9 byte ignored in decode", eccCtrl, 5'b10101);
      decStatus = 5'b01011 ^ {3'b0, badPos[1:0] == 0 ? 2'b00 : 2'b10};
      decErrCnt = badPos[2:0];
      cyc();
      chk(rptValid && rptStatus == decStatus && rptErrCnt == decErrCnt, "R7 decoder report",
          {rptStatus, rptErrCnt}, {decStatus, decErrCnt});
      chk(eccCtrl == 5'b0, "R7 ctrl cleared", eccCtrl, 0);
      decStatus = '0; decErrCnt = '0;
      cyc();
      chk(!rptValid, "R7 report pulse ends", rptValid, 0);
    end
  endtask

  task automatic writeSector(input logic [71:0] p);
    logic [71:0] exp;
    exp = (p == sig) ? {72{1'b1}} : p;
    startSec(1'b1);
    // R9: bytes ignored in program mode
    byteValid = 1'b1; byteIn = 8'h00; cyc(); byteValid = 1'b0;
    chk(!blankValid && !rptValid && eccCtrl == 5'b01101, "R9 byte ignored in program", eccCtrl, 5'b01101);
    encParity = p; encDone = 1'b1;
    cyc();
    encDone = 1'b0;
    chk(parOutValid && parOut == exp, "R3 stored parity", parOut, exp);
    chk(eccCtrl == 5'b0, "R3 ctrl cleared", eccCtrl, 0);
    cyc();
    chk(!parOutValid, "R3 pulse ends", parOutValid, 0);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] sb [9] = '{8'hCD, 8'h9D, 8'h90, 8'h58, 8'hF4, 8'h8B, 8'hFF, 8'hB7, 8'h6F};
    for (int k = 0; k < 9; k++) sig[k*8 +: 8] = sb[k];
    cyc();
    // R1 reset state
    chk(eccCtrl == 0 && !parOutValid && parOut == 0 && !blankValid && !blank && !rptValid
        && rptStatus == 0 && rptErrCnt == 0, "R1 reset outputs", eccCtrl, 0);
    rstN = 1'b1;
    cyc();
    // R9: stray inputs while idle
    byteValid = 1'b1; byteIn = 8'hFF; encDone = 1'b1; encParity = sig;
    cyc(); cyc();
    byteValid = 1'b0; encDone = 1'b0;
    chk(!parOutValid && !blankValid && !rptValid && eccCtrl == 0, "R9 idle stray inputs",
        {parOutValid, blankValid, rptValid, eccCtrl}, 0);
    // R9: count not advanced by idle bytes -> exact sector still blank at 521
    readSector(-1, 8'h00, 1'b0);
    readSector(-1, 8'h00, 1'b1);
    // R5: bad byte sweep across data/parity boundaries
    begin
      int pos [14] = '{0, 1, 7, 8, 255, 256, 510, 511, 512, 513, 516, 518, 519, 520};
      for (int j = 0; j < 14; j++) readSector(pos[j], 8'hFE - j[7:0], j[0]);
    end
    readSector(300, 8'h7F, 1'b0);
    // R8: restart mid-sector clears running AND and count
    startSec(1'b0);
    for (int i = 0; i < 100; i++) begin
      byteValid = 1'b1; byteIn = (i == 50) ? 8'h00 : 8'hFF; cyc();
    end
    byteValid = 1'b0;
    // restart from mid-write too
    startSec(1'b1);
    readSector(-1, 8'h00, 1'b0);
    chk(blank == 1'b1, "R8 restart gives fresh sector", blank, 1);
    // R9: encDone during read load ignored
    startSec(1'b0);
    encDone = 1'b1; encParity = sig; cyc(); encDone = 1'b0;
    chk(!parOutValid && eccCtrl == 5'b00101, "R9 encDone ignored in read", eccCtrl, 5'b00101);
    feed(-1, 8'h00, 1'b0);
    chk(blankValid && blank, "R9 read unaffected by encDone", {blankValid, blank}, 2'b11);
    cyc();
    // R3: signature, single-bit flips, other patterns
    writeSector(sig);
    for (int b = 0; b < 72; b++) writeSector(sig ^ (72'd1 << b));
    writeSector({72{1'b1}});
    writeSector('0);
    writeSector(72'h0123_4567_89AB_CDEF_55);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule